// File: doc/BRIEF.md
# Teletext Request and Bit-Timing Sequencer

This block turns one horizontal sync event into the timing needed to pull a full teletext payload of 360 bits out of an upstream source on a 27 MHz clock. It synchronises the active-low sync input and detects its leading edge. It then raises a data-request window so that the first payload bit lands a fixed 275 clocks (10.2 us) after that edge. A 4-bit offset moves both edges of the window earlier. This covers a source whose data trails its request by that many clocks, so the payload keeps its place on the line.

The payload rate of 6.9375 Mbit/s does not divide 27 MHz. Each bit is therefore held for either three or four clocks, in a pattern that repeats every 37 bits and 144 clocks. The block samples the serial input on the last clock of every bit period. It presents each captured bit with its index and a one-clock valid strobe. A global enable gates the whole sequence.

Top module: `ttx_sequencer`

## Requirements
- R1: After reset, txt_req and bit_vld are low and bit_val and bit_idx are zero.
- R2: If hsync_n is sampled high at one rising edge and low at the next edge E, a line starts. Its line clock 0 is the cycle that follows edge E+2. Only a high-to-low change starts a line, so holding hsync_n low starts exactly one line.
- R3: txt_req is high for line clocks S−ofs through S−ofs+1401, which is a window of 1402 clocks. Here S = 275 − PIPE_DLY (267 by default) and ofs is the value of req_ofs at line start, from 0 to 15.
- R4: req_ofs is captured when the line starts. Later changes to it have no effect on that line.
- R5: Bit 0 starts at line clock S whatever the offset. Bit b lasts 3 clocks when b mod 37 is 9, 18, 27 or 36, and 4 clocks otherwise. So every 37 bits span 144 clocks.
- R6: txt_data is sampled on the last clock of each bit. In the next cycle bit_vld is high for exactly one clock, with bit_val holding the sample and bit_idx holding b (0 to 359). A line yields 360 pulses.
- R7: While txt_en is sampled low at a rising edge, no line starts and any line in progress ends. From the following cycle txt_req and bit_vld are low, and a disabled line produces no request and no valid pulse.
- R8: A new leading edge during a line aborts that line. The sequence restarts from the new edge and delivers a full 360 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_n | input | 1 | Horizontal sync, active low, asynchronous |
| txt_en | input | 1 | Teletext enable |
| req_ofs | input | 4 | Request edge advance in clocks |
| txt_data | input | 1 | Serial payload from the source |
| txt_req | output | 1 | Data-request window |
| bit_vld | output | 1 | One-clock strobe for a captured bit |
| bit_val | output | 1 | Captured bit value |
| bit_idx | output | 9 | Index of the captured bit |

## Verification
The bench counts rising edges from the edge that first samples hsync_n low. The request is due st+2 edges later, where st = 267 − ofs. The first valid pulse is due 273 edges later for every offset, because the timer adds two synchroniser stages, the bit's last clock and one output register. A behavioural model predicts txt_req and the valid, value and index outputs for every edge. The bench compares them at the falling edge that follows, when all registers on the path have settled. Aggregate counts of request clocks and valid pulses per line confirm the window length and the bit count.

// File: rtl/ttx_pkg.sv
`timescale 1ns/1ps
package ttx_pkg;

    typedef enum logic {
        LN_IDLE = 1'b0,
        LN_RUN  = 1'b1
    } line_st_e;

    // Total clocks spanned by nbits payload bits under the short-bit pattern.
    function automatic int bits_to_clks(input int nbits, input int grp,
                                        input int spacing, input int long_clks);
        int total;
        int pos;
        total = 0;
        for (int i = 0; i < nbits; i++) begin
            pos = i % grp;
            if (pos != 0 && (pos % spacing) == 0)
                total += long_clks - 1;
            else
                total += long_clks;
        end
        return total;
    endfunction

endpackage

// File: rtl/ttx_hs_edge.sv
`timescale 1ns/1ps
module ttx_hs_edge #(
    parameter int SYNC_STAGES = 2,
    parameter bit ACTIVE_LOW  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_in,
    output logic line_start
);
    localparam int SH_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [SH_W-1:0] sh;
    } hs_state_t;

    hs_state_t st_d, st_q;
    logic      idle_lvl;

    // Normalise polarity so the shift register idles high.
    generate
        if (ACTIVE_LOW) begin : g_low
            assign idle_lvl = hsync_in;
        end else begin : g_high
            assign idle_lvl = ~hsync_in;
        end
    endgenerate

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[SH_W-2:0], idle_lvl};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sh: '1};
        else        st_q <= st_d;
    end

    assign line_start = st_q.sh[SH_W-1] & ~st_q.sh[SH_W-2];

endmodule

// File: rtl/ttx_line_timer.sv
`timescale 1ns/1ps
module ttx_line_timer
    import ttx_pkg::*;
#(
    parameter int REF_CLKS = 275,
    parameter int PIPE_DLY = 8,
    parameter int OFS_W    = 4,
    parameter int WIN_CLKS = 1402
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             enable,
    input  logic [OFS_W-1:0] ofs,
    output logic             req,
    output logic             samp_win
);
    localparam int SAMP_START = REF_CLKS - PIPE_DLY;
    localparam int LAST_CLK   = SAMP_START + WIN_CLKS - 1;
    localparam int CNT_W      = $clog2(LAST_CLK + 2);

    typedef struct packed {
        line_st_e          st;
        logic [CNT_W-1:0]  cnt;
        logic [OFS_W-1:0]  ofs;
    } tm_state_t;

    tm_state_t st_d, st_q;
    logic [CNT_W-1:0] req_lo, req_hi;
    logic             running;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.st  = LN_IDLE;
            st_d.cnt = '0;
        end else if (line_start) begin
            st_d.st  = LN_RUN;
            st_d.cnt = '0;
            st_d.ofs = ofs;
        end else if (st_q.st == LN_RUN) begin
            if (st_q.cnt == CNT_W'(LAST_CLK)) begin
                st_d.st  = LN_IDLE;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: LN_IDLE, cnt: '0, ofs: '0};
        else        st_q <= st_d;
    end

    assign running  = (st_q.st == LN_RUN);
    assign req_lo   = CNT_W'(SAMP_START) - CNT_W'(st_q.ofs);
    assign req_hi   = req_lo + CNT_W'(WIN_CLKS);
    assign req      = running && (st_q.cnt >= req_lo) && (st_q.cnt < req_hi);
    assign samp_win = running && enable &&
                      (st_q.cnt >= CNT_W'(SAMP_START)) &&
                      (st_q.cnt <= CNT_W'(LAST_CLK));

endmodule

// File: rtl/ttx_bit_seq.sv
`timescale 1ns/1ps
module ttx_bit_seq #(
    parameter int NUM_BITS    = 360,
    parameter int GRP_BITS    = 37,
    parameter int SHORT_EVERY = 9,
    parameter int LONG_CLKS   = 4,
    parameter int IDX_W       = $clog2(NUM_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win,
    input  logic             din,
    output logic             vld,
    output logic             val,
    output logic [IDX_W-1:0] idx
);
    localparam int PH_W  = $clog2(LONG_CLKS);
    localparam int SUB_W = $clog2(SHORT_EVERY);
    localparam int GRP_W = $clog2(GRP_BITS);

    typedef struct packed {
        logic [PH_W-1:0]  phase;
        logic [SUB_W-1:0] sub;
        logic [GRP_W-1:0] grp;
        logic [IDX_W-1:0] cur;
        logic             vld;
        logic             val;
        logic [IDX_W-1:0] oidx;
    } bs_state_t;

    bs_state_t st_d, st_q;
    logic            short_bit;
    logic [PH_W-1:0] last_ph;
    logic            bit_end;

    assign short_bit = (st_q.sub == '0) && (st_q.grp != '0);
    assign last_ph   = short_bit ? PH_W'(LONG_CLKS - 2) : PH_W'(LONG_CLKS - 1);
    assign bit_end   = win && (st_q.phase == last_ph) &&
                       (st_q.cur < IDX_W'(NUM_BITS));

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (!win) begin
            st_d.phase = '0;
            st_d.sub   = '0;
            st_d.grp   = '0;
            st_d.cur   = '0;
        end else if (bit_end) begin
            st_d.vld   = 1'b1;
            st_d.val   = din;
            st_d.oidx  = st_q.cur;
            st_d.phase = '0;
            st_d.cur   = st_q.cur + 1'b1;
            if (st_q.grp == GRP_W'(GRP_BITS - 1)) begin
                st_d.grp = '0;
                st_d.sub = '0;
            end else begin
                st_d.grp = st_q.grp + 1'b1;
                st_d.sub = (st_q.sub == SUB_W'(SHORT_EVERY - 1)) ? '0 : st_q.sub + 1'b1;
            end
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld = st_q.vld;
    assign val = st_q.val;
    assign idx = st_q.oidx;

endmodule

// File: rtl/ttx_sequencer.sv
`timescale 1ns/1ps
module ttx_sequencer #(
    parameter int REF_CLKS    = 275,
    parameter int PIPE_DLY    = 8,
    parameter int OFS_W       = 4,
    parameter int NUM_BITS    = 360,
    parameter int GRP_BITS    = 37,
    parameter int SHORT_EVERY = 9,
    parameter int LONG_CLKS   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int IDX_W       = $clog2(NUM_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_n,
    input  logic             txt_en,
    input  logic [OFS_W-1:0] req_ofs,
    input  logic             txt_data,
    output logic             txt_req,
    output logic             bit_vld,
    output logic             bit_val,
    output logic [IDX_W-1:0] bit_idx
);
    localparam int WIN_CLKS =
        ttx_pkg::bits_to_clks(NUM_BITS, GRP_BITS, SHORT_EVERY, LONG_CLKS);

    logic line_start;
    logic samp_win;

    ttx_hs_edge #(
        .SYNC_STAGES (SYNC_STAGES),
        .ACTIVE_LOW  (1'b1)
    ) i_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync_in   (hsync_n),
        .line_start (line_start)
    );

    ttx_line_timer #(
        .REF_CLKS (REF_CLKS),
        .PIPE_DLY (PIPE_DLY),
        .OFS_W    (OFS_W),
        .WIN_CLKS (WIN_CLKS)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .enable     (txt_en),
        .ofs        (req_ofs),
        .req        (txt_req),
        .samp_win   (samp_win)
    );

    ttx_bit_seq #(
        .NUM_BITS    (NUM_BITS),
        .GRP_BITS    (GRP_BITS),
        .SHORT_EVERY (SHORT_EVERY),
        .LONG_CLKS   (LONG_CLKS),
        .IDX_W       (IDX_W)
    ) i_bits (
        .clk   (clk),
        .rst_n (rst_n),
        .win   (samp_win),
        .din   (txt_data),
        .vld   (bit_vld),
        .val   (bit_val),
        .idx   (bit_idx)
    );

endmodule

// File: rtl/ttx_sequencer_chk.sv
`timescale 1ns/1ps
module ttx_sequencer_chk #(
    parameter int NUM_BITS = 360,
    parameter int IDX_W    = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txt_en,
    input logic             txt_req,
    input logic             bit_vld,
    input logic [IDX_W-1:0] bit_idx,
    input logic             line_start,
    input logic             samp_win
);
    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> (bit_idx < IDX_W'(NUM_BITS)));

    // R6
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> !bit_vld);

    // R7
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !txt_en |=> (!txt_req && !bit_vld));

    // R2
    edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> !line_start);

    // R5
    vld_from_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> $past(samp_win));

    // R8
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && txt_en) |=> !samp_win);

endmodule

bind ttx_sequencer ttx_sequencer_chk #(
    .NUM_BITS (NUM_BITS),
    .IDX_W    (IDX_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .txt_en     (txt_en),
    .txt_req    (txt_req),
    .bit_vld    (bit_vld),
    .bit_idx    (bit_idx),
    .line_start (line_start),
    .samp_win   (samp_win)
);

// File: tb/test_ttx_sequencer.sv
`timescale 1ns/1ps
module test_ttx_sequencer;
    localparam int S_CLK = 275 - 8;   // bit 0 start on the line clock
    localparam int NB    = 360;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_n = 1'b1;
    logic       txt_en = 1'b0;
    logic [3:0] req_ofs = '0;
    logic       txt_data = 1'b0;
    logic       txt_req, bit_vld, bit_val;
    logic [8:0] bit_idx;

    always #2 clk = ~clk;

    ttx_sequencer i_ttx_sequencer (
        .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .txt_en(txt_en),
        .req_ofs(req_ofs), .txt_data(txt_data), .txt_req(txt_req),
        .bit_vld(bit_vld), .bit_val(bit_val), .bit_idx(bit_idx)
    );

    // staged inputs
    logic       s_rst = 1'b0, s_hs = 1'b1, s_en = 1'b0;
    logic [3:0] s_ofs = '0;

    // reference model
    int  tot;
    int  bit_at [0:2047];
    bit  m_act;
    int  m_cnt, m_ofs;
    bit  h1, h2, h3;
    bit  e_req, e_vld, e_val;
    int  e_idx;
    int  m_nvld;

    int  compared = 0, mismatched = 0;
    int  ecount = 0, e0 = 0;
    int  nreq, nvld, rise_d, vld_d;
    bit  done = 1'b0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, exp, ecount);
        end
    endtask

    task automatic model_reset();
        m_act = 0; m_cnt = 0; m_ofs = 0;
        h1 = 1; h2 = 1; h3 = 1;
        e_req = 0; e_vld = 0; e_val = 0; e_idx = 0;
    endtask

    task automatic model_step(input bit hs, input bit en, input int ofs, input bit d);
        bit start;
        start = (h2 == 0) && (h3 == 1);
        e_vld = 0;
        if (m_act && en && m_cnt >= S_CLK && m_cnt < S_CLK + tot)
            if (bit_at[m_cnt - S_CLK] >= 0) begin
                e_vld = 1; e_val = d; e_idx = bit_at[m_cnt - S_CLK]; m_nvld++;
            end
        if (!en) m_act = 0;
        else if (start) begin m_act = 1; m_cnt = 0; m_ofs = ofs; end
        else if (m_act) begin
            if (m_cnt == S_CLK + tot - 1) m_act = 0;
            else m_cnt++;
        end
        e_req = m_act && (m_cnt >= S_CLK - m_ofs) && (m_cnt < S_CLK - m_ofs + tot);
        h3 = h2; h2 = h1; h1 = hs;
    endtask

    task automatic tick();
        bit d;
        @(negedge clk);
        // outputs now reflect edge ecount
        check(txt_req === e_req, "R3 txt_req", int'(txt_req), int'(e_req));
        check(bit_vld === e_vld, "R5 bit_vld", int'(bit_vld), int'(e_vld));
        if (e_vld) begin
            check(bit_val === e_val, "R6 bit_val", int'(bit_val), int'(e_val));
            check(int'(bit_idx) == e_idx, "R6 bit_idx", int'(bit_idx), e_idx);
        end
        if (txt_req) begin nreq++; if (rise_d < 0) rise_d = ecount - e0; end
        if (bit_vld) begin nvld++; if (vld_d < 0) vld_d = ecount - e0; end
        d = 1'($urandom);
        if (hsync_n && !s_hs) e0 = ecount + 1;
        rst_n = s_rst; hsync_n = s_hs; txt_en = s_en; req_ofs = s_ofs; txt_data = d;
        if (!s_rst) model_reset();
        else model_step(s_hs, s_en, int'(s_ofs), d);
        ecount++;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic begin_scn();
        nreq = 0; nvld = 0; rise_d = -1; vld_d = -1; m_nvld = 0;
    endtask

    task automatic hs_pulse(input int low_len);
        s_hs = 0; ticks(low_len); s_hs = 1;
    endtask

    initial begin
        int t, p;
        t = 0;
        for (int i = 0; i < 2048; i++) bit_at[i] = -1;
        for (int b = 0; b < NB; b++) begin
            p = b % 37;
            t += (p != 0 && (p % 9) == 0) ? 3 : 4;
            bit_at[t - 1] = b;
        end
        tot = t;
        model_reset();
        begin_scn();
        ticks(5);
        s_rst = 1; ticks(1);
        // R1 reset state
        check(!txt_req && !bit_vld, "R1 outputs after reset", int'(txt_req) + int'(bit_vld), 0);
        check(bit_idx == 0 && !bit_val, "R1 idx/val after reset", int'(bit_idx), 0);
        ticks(10);

        // A: offset 0
        s_en = 1; s_ofs = 0; ticks(5);
        begin_scn(); hs_pulse(20); ticks(1800);
        check(rise_d == S_CLK + 2, "R2 request delay ofs0", rise_d, S_CLK + 2);
        check(nreq == tot, "R3 window length ofs0", nreq, tot);
        check(vld_d == S_CLK + 6, "R5 first bit delay ofs0", vld_d, S_CLK + 6);
        check(nvld == NB, "R6 pulses per line", nvld, NB);
        check(tot == 1402, "R5 bit timing total", tot, 1402);

        // B: offset 15
        s_ofs = 15; begin_scn(); hs_pulse(20); ticks(1800);
        check(rise_d == S_CLK - 15 + 2, "R3 request delay ofs15", rise_d, S_CLK - 13);
        check(vld_d == S_CLK + 6, "R5 first bit fixed ofs15", vld_d, S_CLK + 6);
        check(nreq == tot, "R3 window length ofs15", nreq, tot);

        // C: offset changed mid-line
        s_ofs = 3; begin_scn(); hs_pulse(20); ticks(30); s_ofs = 12; ticks(1770);
        check(rise_d == S_CLK - 3 + 2, "R4 offset latched", rise_d, S_CLK - 1);
        check(nreq == tot, "R4 window length latched", nreq, tot);

        // D: disabled line
        s_en = 0; begin_scn(); hs_pulse(20); ticks(1800);
        check(nreq == 0 && nvld == 0, "R7 disabled line", nreq + nvld, 0);

        // E: enable dropped mid-line
        s_en = 1; ticks(5); begin_scn(); hs_pulse(20); ticks(600);
        s_en = 0; ticks(3);
        check(!txt_req && !bit_vld, "R7 abort on disable", int'(txt_req) + int'(bit_vld), 0);
        check(nvld == m_nvld && nvld < NB, "R7 partial line", nvld, m_nvld);
        ticks(1300);

        // F: retrigger mid-line
        s_en = 1; ticks(5); begin_scn(); hs_pulse(20); ticks(700);
        hs_pulse(20); ticks(1800);
        check(nvld == m_nvld, "R8 retrigger pulse count", nvld, m_nvld);
        check(nvld > NB, "R8 full line after restart", nvld, NB + 1);

        // G: long low level starts one line only
        begin_scn(); hs_pulse(600); ticks(1400);
        check(nvld == NB, "R2 held-low single line", nvld, NB);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", ecount, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule